// File: doc/BRIEF.md
# Next Program Counter Selector

This block works out the address of the next instruction for a simple single-cycle processor. It takes the current program counter, the two immediate fields of the instruction that was fetched, and three flags: conditional branch, jump, and the ALU zero result. From these it forms three candidate addresses. The first is the sequential address. The second is the branch target, which is a word displacement added to the sequential address. The third is the jump target, which is a word field placed inside the region that the sequential address sits in. A priority decoder picks one route and a multiplexer places that candidate on the output.

There is no storage inside the block. The output depends only on the present inputs. The program counter register, the instruction decoder and the ALU are all outside the block. The route decoder has three named outcomes. ROUTE_SEQ is the default. ROUTE_BRANCH is chosen when the branch flag and the zero flag are both set. ROUTE_JUMP is chosen whenever the jump flag is set. The decoder is re-evaluated on every change of the inputs, and each evaluation moves straight to exactly one of these outcomes.

Top module: `next_pc_unit`

## Requirements
- R1: When is_jump = 0 and is_branch = 0, pc_next equals pc_cur + 4 modulo 2^32 (0xFFFFFFFC wraps to 0x00000000).
- R2: br_disp is a signed 16-bit word count. Bit 15 is copied into every upper bit of the 32-bit offset, so a value of 0xFFFF moves the target back by exactly 4 bytes.
- R3: When is_jump = 0, is_branch = 1 and alu_zero = 1, pc_next equals (pc_cur + 4) + 4 × signed(br_disp), modulo 2^32.
- R4: When is_jump = 0, is_branch = 1 and alu_zero = 0, pc_next equals pc_cur + 4.
- R5: When is_branch = 0 and is_jump = 0, alu_zero has no effect on pc_next.
- R6: When is_jump = 1, pc_next[31:28] equals (pc_cur + 4)[31:28], pc_next[27:2] equals jmp_field, and pc_next[1:0] equals 0.
- R7: is_jump = 1 selects the jump target whatever the values of is_branch and alu_zero.
- R8: br_disp has no effect while is_jump = 1, and jmp_field has no effect while is_jump = 0.
- R9: pc_next follows any change of the inputs in the same time step, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_cur | input | 32 | Current program counter |
| br_disp | input | 16 | Signed branch displacement in words |
| jmp_field | input | 26 | Word-index field of a jump |
| is_branch | input | 1 | Instruction is a conditional branch |
| is_jump | input | 1 | Instruction is an unconditional jump |
| alu_zero | input | 1 | ALU zero result (branch condition) |
| pc_next | output | 32 | Selected next program counter |

## Verification
The only internal state is the route chosen by the decoder, and it is recomputed on every input change. A wrong route therefore shows up on pc_next in the same time step as the input pattern that triggers it, with no delay of one or more cycles. A route error appears as pc_next jumping by the displacement, or by the jump field, when it should step by four, or the reverse. An adder or extension fault does not change the route, but it does give a wrong pc_next, most clearly with negative displacements and with addresses near the top of the address space. The sweep runs through every combination of the three flags, against displacements spread across the whole signed range and against several program counter values, including the wrap-around value.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    typedef enum logic [1:0] {
        ROUTE_SEQ    = 2'd0,
        ROUTE_BRANCH = 2'd1,
        ROUTE_JUMP   = 2'd2
    } route_e;

endpackage

// File: rtl/pc_incrementer.sv
module pc_incrementer #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] pc_in,
    output logic [ADDR_W-1:0] seq_out
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    assign seq_out = pc_in + STEP_V;

endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] target
);

    localparam int EXT_W = ADDR_W - DISP_W - SHIFT;

    logic [ADDR_W-1:0] offset;

    generate
        if (SHIFT > 0) begin : g_shifted
            assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, {SHIFT{1'b0}}};
        end else begin : g_plain
            assign offset = {{EXT_W{disp[DISP_W-1]}}, disp};
        end
    endgenerate

    assign target = base + offset;

endmodule

// File: rtl/jump_target_gen.sv
module jump_target_gen #(
    parameter int ADDR_W  = 32,
    parameter int FIELD_W = 26,
    parameter int SHIFT   = 2
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [FIELD_W-1:0] field,
    output logic [ADDR_W-1:0]  target
);

    localparam int HI_W = ADDR_W - FIELD_W - SHIFT;

    generate
        if (SHIFT > 0) begin : g_shifted
            assign target = {base[ADDR_W-1 -: HI_W], field, {SHIFT{1'b0}}};
        end else begin : g_plain
            assign target = {base[ADDR_W-1 -: HI_W], field};
        end
    endgenerate

endmodule

// File: rtl/next_pc_select.sv
module next_pc_select
    import nextpc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              is_branch,
    input  logic              is_jump,
    input  logic              alu_zero,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic [ADDR_W-1:0] jmp_addr,
    output route_e            route,
    output logic [ADDR_W-1:0] pc_next
);

    // Route decision: jump outranks branch, branch needs its condition.
    always_comb begin
        if (is_jump) begin
            route = ROUTE_JUMP;
        end else if (is_branch && alu_zero) begin
            route = ROUTE_BRANCH;
        end else begin
            route = ROUTE_SEQ;
        end
    end

    // Output mux driven by the route.
    always_comb begin
        pc_next = seq_addr;
        unique case (route)
            ROUTE_SEQ:    pc_next = seq_addr;
            ROUTE_BRANCH: pc_next = br_addr;
            ROUTE_JUMP:   pc_next = jmp_addr;
            default:      pc_next = seq_addr;
        endcase
    end

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
    import nextpc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DISP_W      = 16,
    parameter int JFIELD_W    = 26,
    parameter int INSTR_BYTES = 4
) (
    input  logic [ADDR_W-1:0]   pc_cur,
    input  logic [DISP_W-1:0]   br_disp,
    input  logic [JFIELD_W-1:0] jmp_field,
    input  logic                is_branch,
    input  logic                is_jump,
    input  logic                alu_zero,
    output logic [ADDR_W-1:0]   pc_next
);

    localparam int ALIGN_SH = $clog2(INSTR_BYTES);

    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_addr;
    logic [ADDR_W-1:0] jmp_addr;
    route_e            route;

    pc_incrementer #(
        .ADDR_W (ADDR_W),
        .STEP   (INSTR_BYTES)
    ) u_inc (
        .pc_in   (pc_cur),
        .seq_out (seq_addr)
    );

    branch_target_gen #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .SHIFT  (ALIGN_SH)
    ) u_br (
        .base   (seq_addr),
        .disp   (br_disp),
        .target (br_addr)
    );

    jump_target_gen #(
        .ADDR_W  (ADDR_W),
        .FIELD_W (JFIELD_W),
        .SHIFT   (ALIGN_SH)
    ) u_jmp (
        .base   (seq_addr),
        .field  (jmp_field),
        .target (jmp_addr)
    );

    next_pc_select #(
        .ADDR_W (ADDR_W)
    ) u_sel (
        .is_branch (is_branch),
        .is_jump   (is_jump),
        .alu_zero  (alu_zero),
        .seq_addr  (seq_addr),
        .br_addr   (br_addr),
        .jmp_addr  (jmp_addr),
        .route     (route),
        .pc_next   (pc_next)
    );

endmodule

// File: rtl/next_pc_unit_chk.sv
module next_pc_unit_chk #(
    parameter int ADDR_W      = 32,
    parameter int DISP_W      = 16,
    parameter int JFIELD_W    = 26,
    parameter int INSTR_BYTES = 4
) (
    input logic [ADDR_W-1:0]   pc_cur,
    input logic [DISP_W-1:0]   br_disp,
    input logic [JFIELD_W-1:0] jmp_field,
    input logic                is_branch,
    input logic                is_jump,
    input logic                alu_zero,
    input logic [ADDR_W-1:0]   seq_addr,
    input logic [ADDR_W-1:0]   br_addr,
    input logic [ADDR_W-1:0]   jmp_addr,
    input logic [ADDR_W-1:0]   pc_next
);

    localparam int SH   = $clog2(INSTR_BYTES);
    localparam int HI_W = ADDR_W - JFIELD_W - SH;

    logic [ADDR_W-1:0] step_seen;
    logic [ADDR_W-1:0] br_delta;

    assign step_seen = seq_addr - pc_cur;
    assign br_delta  = br_addr - seq_addr;

    always_comb begin
        // R1
        seq_step_chk: assert (step_seen == ADDR_W'(INSTR_BYTES))
            else $error("sequential step wrong");
        // R2
        sign_ext_chk: assert (br_delta[ADDR_W-1] == br_disp[DISP_W-1])
            else $error("branch offset sign wrong");
        // R3
        br_scale_chk: assert (br_delta[SH +: DISP_W] == br_disp)
            else $error("branch offset scaling wrong");
        // R4
        branch_gate_chk: assert (!(is_branch && !is_jump && !alu_zero) || pc_next == seq_addr)
            else $error("untaken branch left sequence");
        // R5
        no_branch_chk: assert (is_branch || is_jump || pc_next == seq_addr)
            else $error("plain step disturbed");
        // R6
        jmp_fmt_chk: assert (!is_jump ||
                             (pc_next[SH +: JFIELD_W] == jmp_field &&
                              pc_next[ADDR_W-1 -: HI_W] == seq_addr[ADDR_W-1 -: HI_W]))
            else $error("jump target layout wrong");
        // R7
        jump_prio_chk: assert (!is_jump || pc_next == jmp_addr)
            else $error("jump did not win");
    end

endmodule

bind next_pc_unit next_pc_unit_chk #(
    .ADDR_W      (ADDR_W),
    .DISP_W      (DISP_W),
    .JFIELD_W    (JFIELD_W),
    .INSTR_BYTES (INSTR_BYTES)
) u_chk (
    .pc_cur    (pc_cur),
    .br_disp   (br_disp),
    .jmp_field (jmp_field),
    .is_branch (is_branch),
    .is_jump   (is_jump),
    .alu_zero  (alu_zero),
    .seq_addr  (seq_addr),
    .br_addr   (br_addr),
    .jmp_addr  (jmp_addr),
    .pc_next   (pc_next)
);

// File: tb/test_next_pc_unit.sv
module test_next_pc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_cur;
    logic [15:0] br_disp;
    logic [25:0] jmp_field;
    logic        is_branch;
    logic        is_jump;
    logic        alu_zero;
    logic [31:0] pc_next;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    next_pc_unit i_next_pc_unit (
        .pc_cur    (pc_cur),
        .br_disp   (br_disp),
        .jmp_field (jmp_field),
        .is_branch (is_branch),
        .is_jump   (is_jump),
        .alu_zero  (alu_zero),
        .pc_next   (pc_next)
    );

    function automatic logic [31:0] model(input logic [31:0] pc, input logic [15:0] d,
                                          input logic [25:0] j, input logic b,
                                          input logic jp, input logic z);
        logic [31:0] pc4;
        int          sd;
        pc4 = pc + 32'd4;
        sd  = int'($signed(d));
        if (jp)          return (pc4 & 32'hF000_0000) | (32'(j) << 2);
        else if (b && z) return pc4 + 32'(sd * 4);
        else             return pc4;
    endfunction

    task automatic check(input string tag, input logic [31:0] exp);
        checks++;
        if (pc_next !== exp) begin
            errors++;
            $display("FAIL %s: pc_next=%08h expected=%08h (pc=%08h d=%04h j=%07h b=%0b jp=%0b z=%0b)",
                     tag, pc_next, exp, pc_cur, br_disp, jmp_field, is_branch, is_jump, alu_zero);
        end
    endtask

    task automatic apply(input logic [31:0] pc, input logic [15:0] d, input logic [25:0] j,
                         input logic b, input logic jp, input logic z);
        @(negedge clk);
        pc_cur = pc; br_disp = d; jmp_field = j;
        is_branch = b; is_jump = jp; alu_zero = z;
        #2;
    endtask

    function automatic string tag_for(input logic b, input logic jp, input logic z);
        if (jp)      return b ? "R7" : "R6";
        if (b && z)  return "R3";
        if (b)       return "R4";
        return z ? "R5" : "R1";
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: expired, expected run to finish");
        finish_run();
    end

    initial begin
        logic [31:0] ref_v;
        pc_cur = '0; br_disp = '0; jmp_field = '0;
        is_branch = 1'b0; is_jump = 1'b0; alu_zero = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: state after reset with idle inputs
        apply(32'h0, 16'h0, 26'h0, 1'b0, 1'b0, 1'b0);
        check("R1 reset", 32'h4);

        // R1: wrap at the top of the address space
        apply(32'hFFFF_FFFC, 16'h0, 26'h0, 1'b0, 1'b0, 1'b0);
        check("R1 wrap", 32'h0);

        // R2: displacement of -1 word points back at pc
        apply(32'h0000_1000, 16'hFFFF, 26'h0, 1'b1, 1'b0, 1'b1);
        check("R2 minus1", 32'h0000_1000);
        apply(32'h0000_1000, 16'h8000, 26'h0, 1'b1, 1'b0, 1'b1);
        check("R2 mostneg", 32'hFFFE_1004);

        // R3: largest forward displacement
        apply(32'h0000_1000, 16'h7FFF, 26'h0, 1'b1, 1'b0, 1'b1);
        check("R3 maxfwd", 32'h0002_1000);

        // R4: condition false
        apply(32'h0000_1000, 16'h0010, 26'h0, 1'b1, 1'b0, 1'b0);
        check("R4 nottaken", 32'h0000_1004);

        // R5: zero flag alone does nothing
        apply(32'h0000_2000, 16'h0010, 26'h0, 1'b0, 1'b0, 1'b1);
        check("R5 zeroonly", 32'h0000_2004);

        // R6: region bits come from pc+4, including carry into top nibble
        apply(32'h1FFF_FFFC, 16'h0, 26'h3FF_FFFF, 1'b0, 1'b1, 1'b0);
        check("R6 carry", 32'h2FFF_FFFC);

        // R7: jump beats a taken branch
        apply(32'h4000_0000, 16'h0100, 26'h000_0040, 1'b1, 1'b1, 1'b1);
        check("R7 prio", 32'h4000_0100);

        // R8: branch displacement ignored under jump
        apply(32'h4000_0000, 16'hABCD, 26'h000_0040, 1'b1, 1'b1, 1'b1);
        check("R8 dispignored", 32'h4000_0100);
        // R8: jump field ignored without jump
        apply(32'h0000_3000, 16'h0002, 26'h155_5555, 1'b1, 1'b0, 1'b1);
        check("R8 fieldignored", 32'h0000_300C);

        // R9: output follows a mid-cycle change with no clock edge
        @(posedge clk);
        #3;
        pc_cur = 32'h0000_0100; is_branch = 1'b0; is_jump = 1'b0;
        #1;
        check("R9 comb", 32'h0000_0104);

        // Sweep: all flag combinations, spread of displacements and pcs
        for (int p = 0; p < 4; p++) begin
            logic [31:0] pcv;
            pcv = (p == 3) ? 32'hFFFF_FFFC : 32'(p) * 32'h5A3C_1F04;
            for (int f = 0; f < 8; f++) begin
                for (int d = 0; d < 65536; d += 1021) begin
                    logic [25:0] jv;
                    jv = 26'(d * 977 + p);
                    apply(pcv, 16'(d), jv, f[0], f[1], f[2]);
                    ref_v = model(pcv, 16'(d), jv, f[0], f[1], f[2]);
                    check(tag_for(f[0], f[1], f[2]), ref_v);
                end
            end
        end

        finish_run();
    end

endmodule